// File: doc/BRIEF.md
# Instruction Line Request Unit

This unit sits between a multithreaded fetch stage and an instruction memory port. Each hardware thread owns one line buffer. The buffer holds a line address, a valid flag, a one-bit request sequence tag and the line data. A fetch address presented for a thread is aligned to a line boundary and compared with that thread's buffer. A read request for the whole line goes to the memory port only when the buffer does not hold the line.

The memory port can refuse a request. A refused request is parked in a single retry slot shared by all threads, and a global blocked flag stops every thread from issuing until the port signals retry. Returning responses carry a thread id and the sequence tag. A response is written into the buffer only if its thread is still waiting and the tag matches the thread's latest request. Every other response is dropped and counted. A squash on a thread abandons its outstanding request, so a late response for that request is discarded.

Top module: `ilr_request_unit`

## Requirements
- R1: A request carries the fetch address with its low log2(LINE_BYTES) bits cleared, together with the requesting thread id on `req_tid`.
- R2: When the thread's buffer is valid and its line address equals the aligned fetch address, `fetch_hit` is 1 and no request is made.
- R3: Issuing a request stores the aligned address as the thread's line address, clears its valid flag, inverts its sequence tag and drives the new tag on `req_tag`.
- R4: A request refused (`req_ready`=0) is held in the retry slot with its thread, address and tag. `blocked` becomes 1, the thread enters wait-retry (code 2), and no new request is issued while `blocked` is 1.
- R5: On `retry_in` with a full slot, the slot contents are sent again. If `req_ready` is 1 the thread enters wait-response (code 1), the slot empties and `blocked` clears. On `retry_in` with an empty slot, only `blocked` clears.
- R6: A response is taken only when its thread is in wait-response, its tag equals the thread's current tag, and no squash targets that thread in the same cycle. Any other response leaves the buffers unchanged and increments `drop_count` by one.
- R7: A taken response writes the line data and sets the valid flag. The thread enters access-complete (code 3), or blocked (code 4) if its `stall_in` bit is 1.
- R8: A squash puts the thread in squash state (code 5) and abandons its outstanding request. If the retry slot belongs to that thread, the slot empties, no resend occurs, and `blocked` stays 1 until the next `retry_in`.
- R9: No new request is made while `irq_pending` is 1 and `fetch_addr[1:0]` is 00.
- R10: After reset every thread is in run (code 0), all valid flags are 0, `blocked` is 0 and `drop_count` is 0. A thread in run or access-complete with its stall bit set goes to blocked. A blocked or squash-state thread goes to run once its stall bit is 0, and stays blocked otherwise.
- R11: A new request is issued only for a thread in run or access-complete. A thread in any wait, blocked or squash state gets no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_tid | input | 2 | Thread of the fetch address |
| fetch_addr | input | 32 | Fetch byte address |
| irq_pending | input | 1 | Interrupt pending, holds requests at word-aligned addresses |
| stall_in | input | 4 | Per-thread stall from later stages |
| squash_valid | input | 1 | Squash strobe |
| squash_tid | input | 2 | Thread being squashed |
| req_valid | output | 1 | Line read request to memory |
| req_addr | output | 32 | Line-aligned request address |
| req_tid | output | 2 | Requesting thread |
| req_tag | output | 1 | Sequence tag of the request |
| req_ready | input | 1 | Memory port accepts the request this cycle |
| retry_in | input | 1 | Memory port can now take a refused request |
| rsp_valid | input | 1 | Response present |
| rsp_tid | input | 2 | Thread tag of the response |
| rsp_tag | input | 1 | Sequence tag of the response |
| rsp_data | input | 128 | Line data |
| fetch_hit | output | 1 | Fetch address is in the thread's buffer |
| line_data | output | 128 | Buffer contents of thread `fetch_tid` |
| line_valid | output | 4 | Per-thread buffer valid flags |
| thread_state | output | 12 | Per-thread state code, 3 bits each, thread t at bits 3t+2:3t |
| blocked | output | 1 | Global blocked flag |
| drop_count | output | 8 | Count of dropped responses, wrapping |

## Verification
A wrong sequence tag or a stale state would show up as data written from an abandoned request. That is visible as `line_valid` rising, and `drop_count` failing to rise, one cycle after the offending response. A retry slot that keeps the wrong owner or empties at the wrong time shows as a missing or extra `req_valid` on the cycle `retry_in` arrives, or as `blocked` still being set one cycle later. The bench models every buffer, tag, state and the slot behaviourally and compares all outputs each cycle, so any such difference is reported within one clock.

// File: rtl/ilr_pkg.sv
package ilr_pkg;

    typedef enum logic [2:0] {
        TS_RUN        = 3'd0,
        TS_WAIT_RSP   = 3'd1,
        TS_WAIT_RETRY = 3'd2,
        TS_DONE       = 3'd3,
        TS_BLOCKED    = 3'd4,
        TS_SQUASH     = 3'd5
    } thr_state_e;

    // A thread may start a new line request only from these states.
    function automatic logic may_issue(thr_state_e s);
        return (s == TS_RUN) || (s == TS_DONE);
    endfunction

    // Next state when no squash, fill, issue or retry event hits the thread.
    function automatic thr_state_e quiet_next(thr_state_e s, logic stall);
        thr_state_e n;
        n = s;
        case (s)
            TS_RUN, TS_DONE:        if (stall) n = TS_BLOCKED;
            TS_BLOCKED, TS_SQUASH:  n = stall ? TS_BLOCKED : TS_RUN;
            default:                n = s;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ilr_thread_fsm.sv
module ilr_thread_fsm
    import ilr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       squash_i,
    input  logic       fill_i,
    input  logic       issue_i,
    input  logic       port_ready_i,
    input  logic       retry_ok_i,
    input  logic       stall_i,
    output thr_state_e state_o
);

    thr_state_e state_q;
    thr_state_e state_d;

    always_comb begin
        if (squash_i)
            state_d = TS_SQUASH;
        else if (fill_i)
            state_d = stall_i ? TS_BLOCKED : TS_DONE;
        else if (issue_i)
            state_d = port_ready_i ? TS_WAIT_RSP : TS_WAIT_RETRY;
        else if (retry_ok_i)
            state_d = TS_WAIT_RSP;
        else
            state_d = quiet_next(state_q, stall_i);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TS_RUN;
        else     state_q <= state_d;
    end

    assign state_o = state_q;

    // R8: a squash always lands in squash state
    a_r8_squash_state: assert property (@(posedge clk) disable iff (rst)
        squash_i |=> state_q == TS_SQUASH);

    // R5: an accepted resend leads to wait-response unless squashed
    a_r5_retry_to_wait: assert property (@(posedge clk) disable iff (rst)
        (retry_ok_i && !squash_i) |=> state_q == TS_WAIT_RSP);

endmodule

// File: rtl/ilr_line_store.sv
module ilr_line_store #(
    parameter int NUM_THR = 4,
    parameter int TID_W   = 2,
    parameter int ADDR_W  = 32,
    parameter int LINE_W  = 128
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              issue_i,
    input  logic [TID_W-1:0]                  issue_tid_i,
    input  logic [ADDR_W-1:0]                 issue_line_i,
    input  logic                              fill_i,
    input  logic [TID_W-1:0]                  fill_tid_i,
    input  logic [LINE_W-1:0]                 fill_data_i,
    output logic [NUM_THR-1:0]                valid_o,
    output logic [NUM_THR-1:0][ADDR_W-1:0]    line_o,
    output logic [NUM_THR-1:0]                tag_o,
    output logic [NUM_THR-1:0][LINE_W-1:0]    data_o
);

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic              v_q;
        logic              tag_q;
        logic [ADDR_W-1:0] line_q;
        logic [LINE_W-1:0] data_q;
        logic              my_issue;
        logic              my_fill;

        assign my_issue = issue_i && (issue_tid_i == TID_W'(t));
        assign my_fill  = fill_i  && (fill_tid_i  == TID_W'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q    <= 1'b0;
                tag_q  <= 1'b0;
                line_q <= '0;
                data_q <= '0;
            end else if (my_issue) begin
                v_q    <= 1'b0;
                tag_q  <= ~tag_q;
                line_q <= issue_line_i;
            end else if (my_fill) begin
                v_q    <= 1'b1;
                data_q <= fill_data_i;
            end
        end

        assign valid_o[t] = v_q;
        assign line_o[t]  = line_q;
        assign tag_o[t]   = tag_q;
        assign data_o[t]  = data_q;
    end

    // R3: issuing clears the thread's valid flag
    a_r3_issue_clears: assert property (@(posedge clk) disable iff (rst)
        issue_i |=> !valid_o[$past(issue_tid_i)]);

    // R7: a fill marks the buffer valid
    a_r7_fill_sets: assert property (@(posedge clk) disable iff (rst)
        (fill_i && !issue_i) |=> valid_o[$past(fill_tid_i)]);

endmodule

// File: rtl/ilr_retry_slot.sv
module ilr_retry_slot #(
    parameter int TID_W  = 2,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] cap_addr_i,
    input  logic [TID_W-1:0]  cap_tid_i,
    input  logic              cap_tag_i,
    input  logic              retry_i,
    input  logic              port_ready_i,
    input  logic              squash_i,
    input  logic [TID_W-1:0]  squash_tid_i,
    output logic              full_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [TID_W-1:0]  tid_o,
    output logic              tag_o,
    output logic              blocked_o,
    output logic              resend_o,
    output logic              resend_ok_o
);

    typedef struct packed {
        logic              full;
        logic [ADDR_W-1:0] addr;
        logic [TID_W-1:0]  tid;
        logic              tag;
    } slot_t;

    slot_t slot_q;
    logic  blocked_q;
    logic  owner_squashed;

    assign owner_squashed = squash_i && slot_q.full && (squash_tid_i == slot_q.tid);
    assign resend_o       = retry_i && slot_q.full && !owner_squashed;
    assign resend_ok_o    = resend_o && port_ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q    <= '0;
            blocked_q <= 1'b0;
        end else if (capture_i) begin
            slot_q    <= '{full: 1'b1, addr: cap_addr_i, tid: cap_tid_i, tag: cap_tag_i};
            blocked_q <= 1'b1;
        end else begin
            if (owner_squashed || resend_ok_o)
                slot_q.full <= 1'b0;
            if (retry_i && (!resend_o || port_ready_i))
                blocked_q <= 1'b0;
        end
    end

    assign full_o    = slot_q.full;
    assign addr_o    = slot_q.addr;
    assign tid_o     = slot_q.tid;
    assign tag_o     = slot_q.tag;
    assign blocked_o = blocked_q;

    // R8: squashing the slot owner empties the slot but keeps the block
    a_r8_owner_squash: assert property (@(posedge clk) disable iff (rst)
        (owner_squashed && !retry_i && !capture_i) |=> !full_o && blocked_o);

    // R4: the slot is only occupied while the block is up
    a_r4_full_implies_blocked: assert property (@(posedge clk) disable iff (rst)
        full_o |-> blocked_o);

endmodule

// File: rtl/ilr_request_unit.sv
module ilr_request_unit
    import ilr_pkg::*;
#(
    parameter int NUM_THR    = 4,
    parameter int TID_W      = 2,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int CNT_W      = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       fetch_valid,
    input  logic [TID_W-1:0]           fetch_tid,
    input  logic [ADDR_W-1:0]          fetch_addr,
    input  logic                       irq_pending,
    input  logic [NUM_THR-1:0]         stall_in,
    input  logic                       squash_valid,
    input  logic [TID_W-1:0]           squash_tid,
    output logic                       req_valid,
    output logic [ADDR_W-1:0]          req_addr,
    output logic [TID_W-1:0]           req_tid,
    output logic                       req_tag,
    input  logic                       req_ready,
    input  logic                       retry_in,
    input  logic                       rsp_valid,
    input  logic [TID_W-1:0]           rsp_tid,
    input  logic                       rsp_tag,
    input  logic [LINE_BYTES*8-1:0]    rsp_data,
    output logic                       fetch_hit,
    output logic [LINE_BYTES*8-1:0]    line_data,
    output logic [NUM_THR-1:0]         line_valid,
    output logic [NUM_THR*3-1:0]       thread_state,
    output logic                       blocked,
    output logic [CNT_W-1:0]           drop_count
);

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);

    logic [NUM_THR-1:0]             buf_valid;
    logic [NUM_THR-1:0][ADDR_W-1:0] buf_line;
    logic [NUM_THR-1:0]             buf_tag;
    logic [NUM_THR-1:0][LINE_W-1:0] buf_data;
    thr_state_e                     thr_st [NUM_THR];

    logic              slot_full, slot_tag, slot_blocked, resend, resend_ok;
    logic [ADDR_W-1:0] slot_addr;
    logic [TID_W-1:0]  slot_tid;

    logic [ADDR_W-1:0] aligned;
    logic              hit, irq_hold, fetch_squashed, issue, capture, accept;
    logic [CNT_W-1:0]  drop_q;

    assign aligned        = {fetch_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign hit            = buf_valid[fetch_tid] && (buf_line[fetch_tid] == aligned);
    assign irq_hold       = irq_pending && (fetch_addr[1:0] == 2'b00);
    assign fetch_squashed = squash_valid && (squash_tid == fetch_tid);
    assign issue          = fetch_valid && !hit && !slot_blocked && !irq_hold
                            && !fetch_squashed && may_issue(thr_st[fetch_tid]);
    assign capture        = issue && !req_ready;
    assign accept         = rsp_valid && (thr_st[rsp_tid] == TS_WAIT_RSP)
                            && (rsp_tag == buf_tag[rsp_tid])
                            && !(squash_valid && (squash_tid == rsp_tid));

    assign req_valid = resend || issue;
    assign req_addr  = resend ? slot_addr : aligned;
    assign req_tid   = resend ? slot_tid  : fetch_tid;
    assign req_tag   = resend ? slot_tag  : ~buf_tag[fetch_tid];

    ilr_line_store #(
        .NUM_THR(NUM_THR), .TID_W(TID_W), .ADDR_W(ADDR_W), .LINE_W(LINE_W)
    ) u_store (
        .clk(clk), .rst(rst),
        .issue_i(issue), .issue_tid_i(fetch_tid), .issue_line_i(aligned),
        .fill_i(accept), .fill_tid_i(rsp_tid), .fill_data_i(rsp_data),
        .valid_o(buf_valid), .line_o(buf_line), .tag_o(buf_tag), .data_o(buf_data)
    );

    ilr_retry_slot #(.TID_W(TID_W), .ADDR_W(ADDR_W)) u_slot (
        .clk(clk), .rst(rst),
        .capture_i(capture), .cap_addr_i(aligned), .cap_tid_i(fetch_tid),
        .cap_tag_i(~buf_tag[fetch_tid]),
        .retry_i(retry_in), .port_ready_i(req_ready),
        .squash_i(squash_valid), .squash_tid_i(squash_tid),
        .full_o(slot_full), .addr_o(slot_addr), .tid_o(slot_tid), .tag_o(slot_tag),
        .blocked_o(slot_blocked), .resend_o(resend), .resend_ok_o(resend_ok)
    );

    for (genvar t = 0; t < NUM_THR; t++) begin : g_fsm
        ilr_thread_fsm u_fsm (
            .clk(clk), .rst(rst),
            .squash_i(squash_valid && (squash_tid == TID_W'(t))),
            .fill_i(accept && (rsp_tid == TID_W'(t))),
            .issue_i(issue && (fetch_tid == TID_W'(t))),
            .port_ready_i(req_ready),
            .retry_ok_i(resend_ok && (slot_tid == TID_W'(t))),
            .stall_i(stall_in[t]),
            .state_o(thr_st[t])
        );
        assign thread_state[3*t +: 3] = thr_st[t];
    end

    always_ff @(posedge clk) begin
        if (rst)                      drop_q <= '0;
        else if (rsp_valid && !accept) drop_q <= drop_q + 1'b1;
    end

    assign fetch_hit  = fetch_valid && hit;
    assign line_data  = buf_data[fetch_tid];
    assign line_valid = buf_valid;
    assign blocked    = slot_blocked;
    assign drop_count = drop_q;

    // R1: requests are always line aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr[OFF_W-1:0] == '0));

    // R4: a refused issue raises the global block
    a_r4_refuse_blocks: assert property (@(posedge clk) disable iff (rst)
        (issue && !req_ready) |=> blocked);

    // R4: silent port while blocked and no retry
    a_r4_quiet_blocked: assert property (@(posedge clk) disable iff (rst)
        (blocked && !retry_in) |-> !req_valid);

    // R6: every dropped response bumps the counter
    a_r6_drop_counts: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !accept) |=> drop_count == $past(drop_count) + 1'b1);

    // R2: no request on a hit
    a_r2_hit_no_issue: assert property (@(posedge clk) disable iff (rst)
        (fetch_hit && !blocked) |-> !req_valid);

endmodule

// File: tb/sim_ilr_request_unit.sv
module sim_ilr_request_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         fetch_valid;
    logic [1:0]   fetch_tid;
    logic [31:0]  fetch_addr;
    logic         irq_pending;
    logic [3:0]   stall_in;
    logic         squash_valid;
    logic [1:0]   squash_tid;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic [1:0]   req_tid;
    logic         req_tag;
    logic         req_ready;
    logic         retry_in;
    logic         rsp_valid;
    logic [1:0]   rsp_tid;
    logic         rsp_tag;
    logic [127:0] rsp_data;
    logic         fetch_hit;
    logic [127:0] line_data;
    logic [3:0]   line_valid;
    logic [11:0]  thread_state;
    logic         blocked;
    logic [7:0]   drop_count;

    always #4 clk = ~clk;

    ilr_request_unit u0 (.*);

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int           mst   [4];
    logic         mval  [4];
    logic [31:0]  mline [4];
    logic         mtag  [4];
    logic [127:0] mbuf  [4];
    logic         s_full, s_tag, m_blk;
    logic [31:0]  s_addr;
    logic [1:0]   s_tid;
    int           m_cnt;

    task automatic chk(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic idle();
        fetch_valid = 0; fetch_tid = 0; fetch_addr = 0; irq_pending = 0;
        stall_in = 0; squash_valid = 0; squash_tid = 0; req_ready = 1;
        retry_in = 0; rsp_valid = 0; rsp_tid = 0; rsp_tag = 0; rsp_data = 0;
    endtask

    task automatic model_reset();
        for (int t = 0; t < 4; t++) begin
            mst[t] = 0; mval[t] = 0; mline[t] = 0; mtag[t] = 0; mbuf[t] = 0;
        end
        s_full = 0; s_tag = 0; s_addr = 0; s_tid = 0; m_blk = 0; m_cnt = 0;
    endtask

    // Called right after a negedge with inputs set; returns at the next negedge.
    task automatic tick();
        logic [31:0] al;
        logic hitm, irqh, fsq, iss, osq, res, acc, ev, st;
        #1;
        al   = {fetch_addr[31:4], 4'h0};
        hitm = fetch_valid && mval[fetch_tid] && (mline[fetch_tid] == al);
        irqh = irq_pending && (fetch_addr[1:0] == 2'b00);
        fsq  = squash_valid && (squash_tid == fetch_tid);
        iss  = fetch_valid && !hitm && !m_blk && !irqh && !fsq &&
               (mst[fetch_tid] == 0 || mst[fetch_tid] == 3);
        osq  = squash_valid && s_full && (squash_tid == s_tid);
        res  = retry_in && s_full && !osq;
        acc  = rsp_valid && (mst[rsp_tid] == 1) && (rsp_tag == mtag[rsp_tid]) &&
               !(squash_valid && squash_tid == rsp_tid);
        ev   = iss || res;
        chk(req_valid === ev, "R1 R2 R4 R9 R11 req_valid", req_valid, ev);
        if (ev && req_valid === 1'b1) begin
            chk(req_addr === (res ? s_addr : al), "R1 req_addr", req_addr, res ? s_addr : al);
            chk(req_tid === (res ? s_tid : fetch_tid), "R1 req_tid", req_tid, res ? s_tid : fetch_tid);
            chk(req_tag === (res ? s_tag : ~mtag[fetch_tid]), "R3 req_tag", req_tag,
                res ? s_tag : ~mtag[fetch_tid]);
        end
        chk(fetch_hit === hitm, "R2 fetch_hit", fetch_hit, hitm);
        chk(line_data === mbuf[fetch_tid], "R7 line_data", line_data, mbuf[fetch_tid]);
        for (int t = 0; t < 4; t++) begin
            chk(line_valid[t] === mval[t], "R3 R7 line_valid", line_valid[t], mval[t]);
            chk(thread_state[3*t +: 3] === 3'(mst[t]), "R8 R10 thread_state",
                thread_state[3*t +: 3], mst[t]);
        end
        chk(blocked === m_blk, "R4 R5 blocked", blocked, m_blk);
        chk(drop_count === 8'(m_cnt), "R6 drop_count", drop_count, m_cnt);
        @(posedge clk);
        // reference update
        for (int t = 0; t < 4; t++) begin
            st = stall_in[t];
            if (squash_valid && squash_tid == 2'(t)) mst[t] = 5;
            else if (acc && rsp_tid == 2'(t)) mst[t] = st ? 4 : 3;
            else if (iss && fetch_tid == 2'(t)) mst[t] = req_ready ? 1 : 2;
            else if (res && req_ready && s_tid == 2'(t)) mst[t] = 1;
            else if (mst[t] == 0 || mst[t] == 3) begin if (st) mst[t] = 4; end
            else if (mst[t] == 4 || mst[t] == 5) mst[t] = st ? 4 : 0;
        end
        if (iss) begin
            mval[fetch_tid] = 0; mline[fetch_tid] = al; mtag[fetch_tid] = ~mtag[fetch_tid];
        end
        if (acc) begin
            mval[rsp_tid] = 1; mbuf[rsp_tid] = rsp_data;
        end
        if (rsp_valid && !acc) m_cnt = (m_cnt + 1) % 256;
        if (iss && !req_ready) begin
            s_full = 1; s_addr = al; s_tid = fetch_tid; s_tag = mtag[fetch_tid]; m_blk = 1;
        end else begin
            if (osq || (res && req_ready)) s_full = 0;
            if (retry_in && (!res || req_ready)) m_blk = 0;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic fetch(input logic [1:0] t, input logic [31:0] a, input logic rdy);
        fetch_valid = 1; fetch_tid = t; fetch_addr = a; req_ready = rdy;
    endtask

    task automatic respond(input logic [1:0] t, input logic tg, input logic [127:0] d);
        rsp_valid = 1; rsp_tid = t; rsp_tag = tg; rsp_data = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        chk(thread_state === 12'h0, "R10 reset state", thread_state, 0);
        chk(line_valid === 4'h0, "R10 reset valid", line_valid, 0);
        chk(blocked === 1'b0, "R10 reset blocked", blocked, 0);
        chk(drop_count === 8'h0, "R10 reset count", drop_count, 0);

        // R1 R3: miss on thread 0, accepted
        fetch(0, 32'h0000_0104, 1); tick();
        chk(thread_state[2:0] === 3'd1, "R3 wait-response", thread_state[2:0], 1);
        respond(0, 1'b1, 128'hA5A5_0001); tick();
        chk(line_valid[0] === 1'b1, "R7 fill valid", line_valid[0], 1);
        chk(thread_state[2:0] === 3'd3, "R7 access-complete", thread_state[2:0], 3);
        // R2: hit in the same line
        fetch(0, 32'h0000_0108, 1); tick();

        // R4 R5: refusal on thread 1, then retries
        fetch(1, 32'h0000_0200, 0); tick();
        chk(blocked === 1'b1, "R4 blocked set", blocked, 1);
        chk(thread_state[5:3] === 3'd2, "R4 wait-retry", thread_state[5:3], 2);
        fetch(2, 32'h0000_0400, 1); tick();
        retry_in = 1; req_ready = 0; tick();
        chk(blocked === 1'b1, "R5 refused resend keeps block", blocked, 1);
        retry_in = 1; req_ready = 1; tick();
        chk(blocked === 1'b0, "R5 resend accepted", blocked, 0);
        chk(thread_state[5:3] === 3'd1, "R5 wait-response", thread_state[5:3], 1);

        // R6: wrong tag, then squash and late response
        respond(1, 1'b0, 128'hBAD); tick();
        chk(drop_count === 8'd1, "R6 wrong tag dropped", drop_count, 1);
        squash_valid = 1; squash_tid = 1; tick();
        chk(thread_state[5:3] === 3'd5, "R8 squash state", thread_state[5:3], 5);
        respond(1, 1'b1, 128'hBAD2); tick();
        chk(drop_count === 8'd2, "R6 R8 late response dropped", drop_count, 2);
        chk(line_valid[1] === 1'b0, "R6 no fill after squash", line_valid[1], 0);

        // R8: squash of the slot owner
        fetch(2, 32'h0000_0500, 0); tick();
        squash_valid = 1; squash_tid = 2; tick();
        chk(blocked === 1'b1, "R8 block survives squash", blocked, 1);
        fetch(3, 32'h0000_0600, 1); tick();
        retry_in = 1; tick();
        chk(blocked === 1'b0, "R5 retry on empty slot", blocked, 0);

        // R9: interrupt hold, then R7 fill under stall
        fetch(3, 32'h0000_0600, 1); irq_pending = 1; tick();
        chk(thread_state[11:9] === 3'd0, "R9 held by interrupt", thread_state[11:9], 0);
        fetch(3, 32'h0000_0602, 1); irq_pending = 1; tick();
        respond(3, 1'b1, 128'hC3); stall_in = 4'b1000; tick();
        chk(thread_state[11:9] === 3'd4, "R7 fill under stall", thread_state[11:9], 4);
        tick();
        chk(thread_state[11:9] === 3'd0, "R10 unstall to run", thread_state[11:9], 0);

        // random traffic against the reference
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] rt;
            fetch_valid  = ($urandom % 4) != 0;
            fetch_tid    = 2'($urandom);
            fetch_addr   = 32'h1000 + (($urandom % 4) << 4) + ($urandom % 16);
            irq_pending  = ($urandom % 10) == 0;
            stall_in     = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
            squash_valid = ($urandom % 20) == 0;
            squash_tid   = 2'($urandom);
            req_ready    = ($urandom % 4) != 0;
            retry_in     = ($urandom % 4) == 0;
            rt           = 2'($urandom);
            rsp_valid    = ($urandom % 3) == 0;
            rsp_tid      = rt;
            rsp_tag      = (($urandom % 4) == 0) ? 1'($urandom) : mtag[rt];
            rsp_data     = {$urandom, $urandom, $urandom, $urandom};
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule